// File: doc/BRIEF.md
# Two-Sided Bus Connection Controller

This block is the digital decision core of a hot-pluggable two-wire bus buffer. It sits between an upstream and a downstream bus segment. It sees the thresholded data and clock level of each segment, a connection enable, an undervoltage lockout flag and a fault flag from a separate stuck-bus handler. From these it decides when the two segments may be joined. It does not drive the lines itself. It drives four control outputs: a join command for the analog buffers, an active-high ready indication, a precharge enable and a rise-time accelerator enable.

Each side is qualified on its own. A side qualifies in a cycle when a stop condition is seen on it, or when both of its lines have stayed high for a programmable number of clock cycles. The segments are joined only in a cycle in which both sides qualify at once, and only while enable is high, lockout is released and no fault is flagged. After that the join holds through any bus traffic until enable falls, lockout returns or a fault is flagged. The block then isolates the segments at once and must see a fresh qualification before it joins them again.

Top module: `bus_link_ctrl`

## Requirements
- R1: While `uvlo` is high, `link_on`, `ready` and `accel_en` are 0 and `precharge_en` is 1 in the same cycle, whatever the bus lines do. After `uvlo` falls, a fresh qualification of both sides is needed before the segments are joined.
- R2: While `enable` is low, `link_on`, `ready` and `accel_en` are 0 and `precharge_en` is 1. After `enable` returns high, a fresh qualification of both sides is needed before the segments are joined.
- R3: A stop condition on a side is a 0-to-1 change of its synchronized SDA between two consecutive samples while its synchronized SCL is 1 in both samples. A stop condition seen on both sides in the same cycle joins the segments.
- R4: A side is idle once both of its synchronized lines have been 1 for `IDLE_CYCLES` consecutive samples. Any 0 sample on either line of that side restarts the count.
- R5: The join happens only in a cycle where both sides qualify together. A stop condition or an idle period on only one side never joins the segments.
- R6: While joined, `link_on` = 1, `accel_en` = 1 and `precharge_en` = 0. While not joined, `link_on` = 0, `accel_en` = 0 and `precharge_en` = 1.
- R7: `ready` is 1 only when `enable` is high and the segments are joined.
- R8: When `fault` is 1, the outputs fall back to the isolated state in that same cycle. Once `fault` clears, a fresh qualification of both sides is needed before the segments are joined again.
- R9: If a line is held low from power-up onward, the segments are never joined.
- R10: Once joined, the segments stay joined under any bus line activity, as long as `enable` is high, `uvlo` is low and `fault` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_sda | input | 1 | Upstream data level, thresholded |
| up_scl | input | 1 | Upstream clock level, thresholded |
| dn_sda | input | 1 | Downstream data level, thresholded |
| dn_scl | input | 1 | Downstream clock level, thresholded |
| enable | input | 1 | Connection enable |
| uvlo | input | 1 | Supply lockout active |
| fault | input | 1 | Stuck-bus fault from the recovery block |
| link_on | output | 1 | Join the two segments |
| ready | output | 1 | Connection ready, active high |
| precharge_en | output | 1 | Apply line precharge |
| accel_en | output | 1 | Enable rise-time accelerators |

## Verification
Directed sequences cover several cases. A stop on both sides at once shows that a stop alone can join the segments before any idle count could mature. A stop on only one side, with the other clock held low, shows that a single side is not enough. An idle period broken by a one-cycle low glitch shows that the counter restarts. A line held low from lockout onward shows that no join ever happens. Fault, enable and lockout are each dropped while joined; the bench checks that the outputs react in the same cycle and that no join follows until a full new idle period has passed. After these, seeded random line activity mixed with random control pulses is compared cycle by cycle against a reference model written in the bench. This model separates stop-driven joins from idle-driven joins, and it separates joins that follow a fresh qualification from joins that would rely on a stale count.

// File: rtl/bus_link_pkg.sv
// Shared types for the bus connection controller.
package bus_link_pkg;

    // Connection state: held off, waiting for qualification, joined.
    typedef enum logic [1:0] {
        LINK_HOLD = 2'd0,
        LINK_WAIT = 2'd1,
        LINK_UP   = 2'd2
    } link_state_e;

    // Side indices used by the per-side generate loop.
    localparam int SIDE_UP = 0;
    localparam int SIDE_DN = 1;
    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/line_sync.sv
// line_sync: multi-stage flop synchronizer for a vector of asynchronous levels.
// Assumes each bit is an independent level; no bus coherency is implied.
// Resets all stages to 0 so that an idle bus must be observed, not assumed.
module line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First capture flop for the raw levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= '0;
                    else        pipe[0] <= d_async;
                end
            end else begin : g_next
                // Further stages reduce metastability risk.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[i] <= '0;
                    else        pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = pipe[STAGES-1];

endmodule

// File: rtl/side_qual.sv
// side_qual: qualifies one bus segment as safe to join.
// A side qualifies in a cycle when a stop condition (SDA rising while SCL is
// high in two consecutive synchronized samples) is seen, or when both lines
// have been high for IDLE_CYCLES consecutive samples. The idle count is
// cleared while 'clear' is high so that a fresh idle period is required.
// Assumes IDLE_CYCLES >= 1.
module side_qual #(
    parameter int IDLE_CYCLES = 11875,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sda_raw,
    input  logic scl_raw,
    output logic qualified
);

    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] IDLE_TERM = CW'(IDLE_CYCLES);

    logic [1:0]    cur;      // {sda, scl} synchronized
    logic [1:0]    prev;     // previous synchronized sample
    logic [CW-1:0] idle_cnt;
    logic          stop_seen;
    logic          idle_seen;
    logic          both_high;

    line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sda_raw, scl_raw}),
        .q_sync  (cur)
    );

    // Keep one sample of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= cur;
    end

    assign both_high = cur[1] & cur[0];

    // Count consecutive high samples, saturating at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !both_high) idle_cnt <= '0;
        else if (idle_cnt != IDLE_TERM)    idle_cnt <= idle_cnt + 1'b1;
    end

    // Stop: data rises while clock is high before and after.
    always_comb begin
        stop_seen = cur[1] & ~prev[1] & cur[0] & prev[0];
        idle_seen = (idle_cnt == IDLE_TERM);
        qualified = stop_seen | idle_seen;
    end

    // R4
    idle_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_seen |-> $past(both_high));

    // R3
    stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !stop_seen);

endmodule

// File: rtl/link_fsm.sv
// link_fsm: connection state machine.
// HOLD while lockout or disabled; WAIT until both sides qualify in the same
// cycle; UP until enable drops, lockout returns or a fault is flagged.
// A fault sends the machine back to WAIT.
module link_fsm
    import bus_link_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic uvlo,
    input  logic fault,
    input  logic qual_up,
    input  logic qual_dn,
    output logic link_q
);

    link_state_e state_q, state_d;

    // Next-state selection with lockout, enable, fault priority.
    always_comb begin
        state_d = state_q;
        if (uvlo || !enable) begin
            state_d = LINK_HOLD;
        end else if (fault) begin
            state_d = LINK_WAIT;
        end else begin
            case (state_q)
                LINK_HOLD: state_d = LINK_WAIT;
                LINK_WAIT: if (qual_up && qual_dn) state_d = LINK_UP;
                LINK_UP:   state_d = LINK_UP;
                default:   state_d = LINK_HOLD;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINK_HOLD;
        else        state_q <= state_d;
    end

    assign link_q = (state_q == LINK_UP);

    // R1
    uvlo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> !link_q);

    // R2
    enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !link_q);

    // R8
    fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !link_q);

    // R5
    join_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_q) |-> $past(qual_up && qual_dn));

endmodule

// File: rtl/bus_link_ctrl.sv
// bus_link_ctrl: top of the two-sided bus connection controller.
// Qualifies each segment separately and joins them when both qualify at
// once, gated by enable, lockout release and absence of fault. The gating
// inputs act on the outputs in the same cycle. Bus levels are assumed
// already thresholded; control inputs are assumed synchronous to clk.
module bus_link_ctrl
    import bus_link_pkg::*;
#(
    parameter int IDLE_CYCLES = 11875,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_sda,
    input  logic up_scl,
    input  logic dn_sda,
    input  logic dn_scl,
    input  logic enable,
    input  logic uvlo,
    input  logic fault,
    output logic link_on,
    output logic ready,
    output logic precharge_en,
    output logic accel_en
);

    logic [NUM_SIDES-1:0] sda_v;
    logic [NUM_SIDES-1:0] scl_v;
    logic [NUM_SIDES-1:0] qual_v;
    logic                 qual_clear;
    logic                 live;
    logic                 link_q;

    assign sda_v = {dn_sda, up_sda};
    assign scl_v = {dn_scl, up_scl};

    // Idle counts restart whenever the link is held off or faulted.
    assign qual_clear = uvlo | ~enable | fault;

    generate
        for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
            side_qual #(
                .IDLE_CYCLES (IDLE_CYCLES),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_qual (
                .clk       (clk),
                .rst_n     (rst_n),
                .clear     (qual_clear),
                .sda_raw   (sda_v[s]),
                .scl_raw   (scl_v[s]),
                .qualified (qual_v[s])
            );
        end
    endgenerate

    link_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .uvlo    (uvlo),
        .fault   (fault),
        .qual_up (qual_v[SIDE_UP]),
        .qual_dn (qual_v[SIDE_DN]),
        .link_q  (link_q)
    );

    // Output gating: isolate immediately on any hold condition.
    always_comb begin
        live         = enable & ~uvlo & ~fault;
        link_on      = link_q & live;
        ready        = link_q & live;
        accel_en     = link_q & live;
        precharge_en = ~(link_q & live);
    end

    // R7
    ready_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (enable && !uvlo));

    // R10
    link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(link_on) && enable && !uvlo && !fault) |-> link_on);

endmodule

// File: tb/bus_link_ctrl_bench.sv
module bus_link_ctrl_bench;

    localparam int IDLE = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_sda = 1'b1, up_scl = 1'b1, dn_sda = 1'b1, dn_scl = 1'b1;
    logic enable = 1'b0, uvlo = 1'b1, fault = 1'b0;
    logic link_on, ready, precharge_en, accel_en;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bus_link_ctrl #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) u_bus_link_ctrl (
        .clk(clk), .rst_n(rst_n),
        .up_sda(up_sda), .up_scl(up_scl), .dn_sda(dn_sda), .dn_scl(dn_scl),
        .enable(enable), .uvlo(uvlo), .fault(fault),
        .link_on(link_on), .ready(ready),
        .precharge_en(precharge_en), .accel_en(accel_en)
    );

    // Reference model state: index 0 upstream, 1 downstream; bits {sda,scl}.
    logic [1:0] ms1 [2];
    logic [1:0] ms2 [2];
    logic [1:0] mp  [2];
    int         mcnt [2];
    int         mstate;   // 0 hold, 1 wait, 2 up

    function automatic logic side_q(input logic [1:0] c, input logic [1:0] p, input int n);
        return (c[1] & ~p[1] & c[0] & p[0]) | (n == IDLE);
    endfunction

    function automatic logic exp_link();
        return (mstate == 2) & enable & ~uvlo & ~fault;
    endfunction

    // Advance the model by one rising edge using the current inputs.
    task automatic model_step();
        logic q0, q1;
        logic [1:0] inp [2];
        inp[0] = {up_sda, up_scl};
        inp[1] = {dn_sda, dn_scl};
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                ms1[k] = 2'b00; ms2[k] = 2'b00; mp[k] = 2'b00; mcnt[k] = 0;
            end
            mstate = 0;
        end else begin
            q0 = side_q(ms2[0], mp[0], mcnt[0]);
            q1 = side_q(ms2[1], mp[1], mcnt[1]);
            if (uvlo || !enable) mstate = 0;
            else if (fault) mstate = 1;
            else if (mstate == 0) mstate = 1;
            else if (mstate == 1 && q0 && q1) mstate = 2;
            for (int k = 0; k < 2; k++) begin
                if (uvlo || !enable || fault || !(ms2[k] == 2'b11)) mcnt[k] = 0;
                else if (mcnt[k] != IDLE) mcnt[k] = mcnt[k] + 1;
                mp[k]  = ms2[k];
                ms2[k] = ms1[k];
                ms1[k] = inp[k];
            end
        end
    endtask

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: model the edge, then compare every output at the falling edge.
    task automatic tick();
        string req;
        logic e;
        model_step();
        @(negedge clk);
        e = exp_link();
        if (uvlo) req = "R1";
        else if (!enable) req = "R2";
        else if (fault) req = "R8";
        else req = "R6";
        check_bit(req, "link_on", link_on, e);
        check_bit("R7", "ready", ready, e);
        check_bit(req, "accel_en", accel_en, e);
        check_bit(req, "precharge_en", precharge_en, ~e);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_lines(input logic us, input logic uc, input logic ds, input logic dc);
        up_sda = us; up_scl = uc; dn_sda = ds; dn_scl = dc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D1E_5EED));
        @(negedge clk);
        ticks(4);
        rst_n = 1'b1;
        // Reset and lockout state (R1)
        tick();
        check_bit("R1", "reset link_on", link_on, 1'b0);
        check_bit("R1", "reset precharge", precharge_en, 1'b1);
        enable = 1'b1;
        ticks(40);
        check_bit("R1", "lockout with idle bus", link_on, 1'b0);

        // Powering into a stuck-low line (R9)
        up_sda = 1'b0;
        ticks(3);
        uvlo = 1'b0;
        ticks(300);
        check_bit("R9", "stuck low no join", link_on, 1'b0);

        // Stop on one side only, other side clock low (R5)
        up_scl = 1'b1; dn_scl = 1'b0;
        ticks(4);
        up_sda = 1'b1;
        ticks(10);
        check_bit("R5", "one-sided stop", link_on, 1'b0);

        // Stop on both sides together joins before idle can mature (R3)
        set_lines(1'b0, 1'b1, 1'b0, 1'b1);
        ticks(3);
        up_sda = 1'b1; dn_sda = 1'b1;
        ticks(5);
        check_bit("R3", "dual stop join", link_on, 1'b1);
        check_bit("R6", "accel on join", accel_en, 1'b1);
        check_bit("R6", "precharge off on join", precharge_en, 1'b0);

        // Bus traffic while joined (R10)
        for (int i = 0; i < 60; i++) begin
            set_lines(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            tick();
        end
        check_bit("R10", "held through traffic", link_on, 1'b1);

        // Fault drops at once and needs a fresh idle period (R8)
        set_lines(1'b1, 1'b1, 1'b1, 1'b1);
        ticks(3);
        fault = 1'b1;
        tick();
        check_bit("R8", "fault same cycle", link_on, 1'b0);
        fault = 1'b0;
        ticks(5);
        check_bit("R8", "no stale rejoin", link_on, 1'b0);
        ticks(25);
        check_bit("R8", "rejoin after idle", link_on, 1'b1);

        // Enable low isolates and clears ready (R2, R7)
        enable = 1'b0;
        tick();
        check_bit("R2", "disabled link", link_on, 1'b0);
        check_bit("R7", "disabled ready", ready, 1'b0);
        ticks(2);
        enable = 1'b1;

        // Idle count restarts on a one-cycle glitch (R4)
        ticks(15);
        dn_scl = 1'b0;
        tick();
        dn_scl = 1'b1;
        ticks(15);
        check_bit("R4", "glitch restarts idle", link_on, 1'b0);
        ticks(10);
        check_bit("R4", "idle join", link_on, 1'b1);

        // Lockout while joined (R1)
        uvlo = 1'b1;
        tick();
        check_bit("R1", "lockout drops link", link_on, 1'b0);
        check_bit("R1", "lockout precharge", precharge_en, 1'b1);
        uvlo = 1'b0;
        ticks(3);
        check_bit("R1", "no rejoin right after lockout", link_on, 1'b0);

        // Seeded random phase against the model
        for (int i = 0; i < 6000; i++) begin
            if (up_sda ? ($urandom_range(15) == 0) : ($urandom_range(2) == 0)) up_sda = ~up_sda;
            if (up_scl ? ($urandom_range(15) == 0) : ($urandom_range(2) == 0)) up_scl = ~up_scl;
            if (dn_sda ? ($urandom_range(15) == 0) : ($urandom_range(2) == 0)) dn_sda = ~dn_sda;
            if (dn_scl ? ($urandom_range(15) == 0) : ($urandom_range(2) == 0)) dn_scl = ~dn_scl;
            if ($urandom_range(399) == 0) enable = ~enable;
            if (!enable && $urandom_range(30) == 0) enable = 1'b1;
            if (uvlo) begin
                if ($urandom_range(19) == 0) uvlo = 1'b0;
            end else if ($urandom_range(799) == 0) uvlo = 1'b1;
            fault = ($urandom_range(299) == 0);
            tick();
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule